// File: doc/BRIEF.md
# PCI Outbound Address Window Translator

This block sits between an internal 32-bit system bus and a PCI master. For each access it decides which fixed outbound window the address falls into: one of three PCI memory windows, the 2 MB controller register window or the 2 MB PCI I/O window. For the memory windows it also builds the address that goes out on PCI. An access that lands in no window is flagged as a miss.

The upper part of the PCI memory address comes from a bank register that software programs. A mask register chooses, bit by bit, whether each upper bit comes from the bank value or passes through from the system address. This lets software map a window of 16 MB up to 512 MB anywhere in PCI memory space. The largest window decodes only while the extended 32-bit address mode input is high.

Decode and translation are registered, so all results appear one clock after the request strobe.

Top module: `pci_window_xlate`

## Requirements
- R1: Memory window 0 covers system addresses 0xFD000000 through 0xFDFFFFFF. A valid access in that range sets `mem_hit[0]` alone.
- R2: Memory window 1 covers 0x10000000 through 0x13FFFFFF and sets `mem_hit[1]` alone. Addresses 0x0FFFFFF8 and 0x14000000 are outside it.
- R3: Memory window 2 covers 0xC0000000 through 0xDFFFFFFF and sets `mem_hit[2]` only when `ext_mode` was high with the request. When `ext_mode` is low, the same addresses give a miss.
- R4: The register window covers 0xFE000000 through 0xFE1FFFFF and sets `reg_hit`. The I/O window covers 0xFE200000 through 0xFE3FFFFF and sets `io_hit`.
- R5: A valid access that matches no enabled window raises `miss` for exactly one cycle, with every hit flag low. At most one of the hit and miss outputs is high in any cycle.
- R6: On a memory-window hit, `pci_addr[17:3]` equals system address bits [17:3], and `pci_addr[2:0]` is always zero.
- R7: On a memory-window hit, each bit n of `pci_addr`, for n from 18 to 31, is taken as follows:
  - from system address bit n when mask bit n is 1;
  - otherwise from bank bit n.
- R8: When `cfg_we` is high, the register chosen by `cfg_sel` (0 = bank, 1 = mask) captures `cfg_wdata[31:18]`. An access in the same cycle as a write uses the old value. Accesses from the next cycle onward use the new value.
- R9: Every output is registered. Results appear with `out_valid` one clock after `req_valid`. In a cycle with no request result, all hit flags, `miss` and `pci_addr` are zero.
- R10: On a register-window hit, an I/O-window hit or a miss, `pci_addr` is zero.
- R11: After reset:
  - all outputs are zero;
  - the bank and mask registers hold zero, so upper PCI address bits come out as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | System access strobe |
| req_addr | input | 32 | System bus address |
| ext_mode | input | 1 | Extended 32-bit address mode enable |
| cfg_we | input | 1 | Bank/mask register write enable |
| cfg_sel | input | 1 | Write target: 0 bank, 1 mask |
| cfg_wdata | input | 32 | Write data; bits [31:18] are stored |
| out_valid | output | 1 | Result valid, one cycle after req_valid |
| mem_hit | output | 3 | Memory window 2..0 hit |
| reg_hit | output | 1 | Register window hit |
| io_hit | output | 1 | PCI I/O window hit |
| miss | output | 1 | Access hit no enabled window |
| pci_addr | output | 32 | Translated PCI memory address |

## Verification
The bench drives each window at its first and last 8-byte address, and the words just outside windows 1 and the I/O window. This separates a correct range compare from an off-by-one or a wrong size. Window 2 is driven with the mode flag both low and high, which shows whether the gating is present. Translation uses addresses with non-zero low bits, and a bank and mask that differ bit by bit from the address, so the bench can see which source each PCI bit comes from. A register write in the same cycle as an access shows whether the old or the new value is used.

// File: rtl/pcwin_pkg.sv
package pcwin_pkg;
  localparam int ADDR_W   = 32;
  localparam int XLAT_LSB = 18;
  localparam int ALIGN_W  = 3;
  localparam int UP_W     = ADDR_W - XLAT_LSB;
  localparam int NUM_WIN  = 5;
  localparam int NUM_MEM  = 3;

  // window order: mem0, mem1, mem2, register, io
  localparam logic [ADDR_W-1:0] WIN_BASE [NUM_WIN] =
    '{32'hFD00_0000, 32'h1000_0000, 32'hC000_0000, 32'hFE00_0000, 32'hFE20_0000};
  localparam int WIN_LG [NUM_WIN] = '{24, 26, 29, 21, 21};
  localparam logic WIN_EXT_ONLY [NUM_WIN] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

  typedef enum logic {CFG_BANK = 1'b0, CFG_MASK = 1'b1} cfg_sel_e;
endpackage

// File: rtl/pcwin_decode.sv
module pcwin_decode
  import pcwin_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic               ext_mode,
  output logic [NUM_WIN-1:0] hit,
  output logic               none
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int LG = WIN_LG[w];
    localparam logic [ADDR_W-1:0] BASE = WIN_BASE[w];
    logic match;
    assign match = (addr[ADDR_W-1:LG] == BASE[ADDR_W-1:LG]);
    if (WIN_EXT_ONLY[w]) begin : g_gated
      assign hit[w] = match & ext_mode;
    end else begin : g_plain
      assign hit[w] = match;
    end
  end
  assign none = ~(|hit);
endmodule

// File: rtl/pcwin_bankregs.sv
module pcwin_bankregs
  import pcwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [UP_W-1:0]   bank,
  output logic [UP_W-1:0]   mask
);
  logic [UP_W-1:0] bank_nxt, mask_nxt;
  logic            bank_en, mask_en;

  always_comb begin
    bank_en  = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_BANK);
    mask_en  = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_MASK);
    bank_nxt = cfg_wdata[ADDR_W-1:XLAT_LSB];
    mask_nxt = cfg_wdata[ADDR_W-1:XLAT_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank <= '0;
      mask <= '0;
    end else begin
      if (bank_en) bank <= bank_nxt;
      if (mask_en) mask <= mask_nxt;
    end
  end
endmodule

// File: rtl/pcwin_xlate.sv
module pcwin_xlate
  import pcwin_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [UP_W-1:0]   bank,
  input  logic [UP_W-1:0]   mask,
  output logic [ADDR_W-1:0] pci
);
  logic [UP_W-1:0] upper;
  for (genvar b = 0; b < UP_W; b++) begin : g_bit
    assign upper[b] = mask[b] ? addr[XLAT_LSB+b] : bank[b];
  end
  assign pci = {upper, addr[XLAT_LSB-1:ALIGN_W], {ALIGN_W{1'b0}}};
endmodule

// File: rtl/pci_window_xlate.sv
module pci_window_xlate
  import pcwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic              ext_mode,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic              out_valid,
  output logic [2:0]        mem_hit,
  output logic              reg_hit,
  output logic              io_hit,
  output logic              miss,
  output logic [31:0]       pci_addr
);
  logic [NUM_WIN-1:0] win_hit;
  logic               win_none;
  logic [UP_W-1:0]    bank, mask;
  logic [ADDR_W-1:0]  xl_addr;

  logic               valid_nxt, miss_nxt, reg_nxt, io_nxt;
  logic [NUM_MEM-1:0] mem_nxt;
  logic [ADDR_W-1:0]  pci_nxt;

  pcwin_decode u_dec (
    .addr(req_addr), .ext_mode(ext_mode), .hit(win_hit), .none(win_none));

  pcwin_bankregs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bank(bank), .mask(mask));

  pcwin_xlate u_xl (
    .addr(req_addr), .bank(bank), .mask(mask), .pci(xl_addr));

  always_comb begin
    valid_nxt = req_valid;
    mem_nxt   = req_valid ? win_hit[NUM_MEM-1:0] : '0;
    reg_nxt   = req_valid & win_hit[NUM_MEM];
    io_nxt    = req_valid & win_hit[NUM_MEM+1];
    miss_nxt  = req_valid & win_none;
    pci_nxt   = (|mem_nxt) ? xl_addr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mem_hit   <= '0;
      reg_hit   <= 1'b0;
      io_hit    <= 1'b0;
      miss      <= 1'b0;
      pci_addr  <= '0;
    end else begin
      out_valid <= valid_nxt;
      mem_hit   <= mem_nxt;
      reg_hit   <= reg_nxt;
      io_hit    <= io_nxt;
      miss      <= miss_nxt;
      pci_addr  <= pci_nxt;
    end
  end
endmodule

// File: rtl/pcwin_checker.sv
module pcwin_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        ext_mode,
  input logic        out_valid,
  input logic [2:0]  mem_hit,
  input logic        reg_hit,
  input logic        io_hit,
  input logic        miss,
  input logic [31:0] pci_addr
);
  assert_one_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({mem_hit, reg_hit, io_hit, miss}) == 1);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ({mem_hit, reg_hit, io_hit, miss} == 6'b0 && pci_addr == 32'b0));

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  assert_ext_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ext_mode && req_addr[31:29] == 3'b110) |=> (miss && !mem_hit[2]));

  assert_low_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31:24] == 8'hFD) |=> pci_addr[17:3] == $past(req_addr[17:3]));

  assert_align_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pci_addr[2:0] == 3'b0);

  assert_nonmem_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_hit || io_hit || miss) |-> pci_addr == 32'b0);
endmodule

bind pci_window_xlate pcwin_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .ext_mode(ext_mode), .out_valid(out_valid), .mem_hit(mem_hit),
  .reg_hit(reg_hit), .io_hit(io_hit), .miss(miss), .pci_addr(pci_addr));

// File: tb/pci_window_xlate_test.sv
module pci_window_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, ext_mode, cfg_we, cfg_sel;
  logic [31:0] req_addr, cfg_wdata;
  logic        out_valid, reg_hit, io_hit, miss;
  logic [2:0]  mem_hit;
  logic [31:0] pci_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_bank = 32'h0, m_mask = 32'h0;
  logic [38:0] exp_v = 39'h0;
  string       exp_req = "R11";

  always #4 clk = ~clk;

  pci_window_xlate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .ext_mode(ext_mode), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .mem_hit(mem_hit), .reg_hit(reg_hit), .io_hit(io_hit),
    .miss(miss), .pci_addr(pci_addr));

  function automatic logic [38:0] model(input logic v, input logic [31:0] a, input logic e);
    logic [2:0] mh; logic rh, ih, ms; logic [31:0] pa;
    if (!v) return 39'h0;
    mh[0] = (a >= 32'hFD00_0000) && (a <= 32'hFDFF_FFFF);
    mh[1] = (a >= 32'h1000_0000) && (a <= 32'h13FF_FFFF);
    mh[2] = e && (a >= 32'hC000_0000) && (a <= 32'hDFFF_FFFF);
    rh = (a >= 32'hFE00_0000) && (a < 32'hFE20_0000);
    ih = (a >= 32'hFE20_0000) && (a < 32'hFE40_0000);
    ms = !(mh != 3'b0 || rh || ih);
    pa = 32'h0;
    if (mh != 3'b0)
      for (int b = 3; b < 32; b++)
        pa[b] = (b < 18) ? a[b] : (m_mask[b] ? a[b] : m_bank[b]);
    return {1'b1, mh, rh, ih, ms, pa};
  endfunction

  task automatic compare();
    logic [38:0] act;
    act = {out_valid, mem_hit, reg_hit, io_hit, miss, pci_addr};
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", exp_req, act, exp_v);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic e,
                      input logic we, input logic sel, input logic [31:0] d,
                      input string req);
    @(negedge clk);
    compare();
    req_valid = v; req_addr = a; ext_mode = e;
    cfg_we = we; cfg_sel = sel; cfg_wdata = d;
    exp_v = model(v, a, e);
    exp_req = req;
    if (we) begin
      if (sel) m_mask = d & 32'hFFFC_0000;
      else     m_bank = d & 32'hFFFC_0000;
    end
  endtask

  task automatic acc(input logic [31:0] a, input logic e, input string req);
    step(1'b1, a, e, 1'b0, 1'b0, 32'h0, req);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_addr = 0; ext_mode = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state; zero bank/mask gives zero upper bits
    step(0, 32'h0, 0, 0, 0, 32'h0, "R11");
    acc(32'hFD12_345F, 0, "R11");
    // R1 window 0 edges
    acc(32'hFD00_0000, 0, "R1");
    acc(32'hFDFF_FFF8, 0, "R1");
    // R2 window 1 and neighbours
    acc(32'h1000_0000, 0, "R2");
    acc(32'h13FF_FFFF, 0, "R2");
    acc(32'h0FFF_FFF8, 0, "R2");
    acc(32'h1400_0000, 0, "R2");
    // R3 ext gating
    acc(32'hC000_0000, 0, "R3");
    acc(32'hDFFF_FFF8, 1, "R3");
    acc(32'hC000_0008, 1, "R3");
    acc(32'hE000_0000, 1, "R3");
    // R4 register and io windows
    acc(32'hFE00_0000, 0, "R4");
    acc(32'hFE1F_FFF8, 0, "R4");
    acc(32'hFE20_0000, 0, "R4");
    acc(32'hFE3F_FFF8, 0, "R4");
    // R5 misses, back to back
    acc(32'hFE40_0000, 0, "R5");
    acc(32'h0000_0000, 0, "R5");
    step(0, 32'hFD00_0000, 0, 0, 0, 32'h0, "R9");
    // R8 bank write with same-cycle access (old value used)
    step(1, 32'h1234_5678, 0, 1, 0, 32'hA5A5_FFFF, "R8");
    acc(32'h1234_5678, 0, "R8");
    // R8 mask write, then R7 mixing
    step(1, 32'h1234_5678, 0, 1, 1, 32'h1F00_0000, "R8");
    acc(32'h1234_5678, 0, "R7");
    acc(32'hFDAB_CDEF, 0, "R7");
    acc(32'hD555_5557, 1, "R7");
    step(0, 32'h0, 0, 1, 1, 32'h5555_5555, "R9");
    acc(32'hDAAA_AAAC, 1, "R7");
    acc(32'h1FFF_FFF8, 0, "R6");
    acc(32'hFDFF_FFFF, 0, "R6");
    acc(32'hFE30_0007, 0, "R10");
    step(0, 32'h0, 0, 0, 0, 32'h0, "R9");
    step(0, 32'h0, 0, 0, 0, 32'h0, "R9");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule